// File: doc/BRIEF.md
# Mono Pattern Color Expander

This block turns an 8x8 one-bit fill pattern into the color of a single pixel during a pattern blit. The pattern arrives as two 32-bit words. The low word holds the top four rows and the high word holds the bottom four. A foreground color and a background color come with it. For each destination coordinate presented, the block finds the pattern cell under that pixel and returns the matching color.

The pattern is tied to the destination grid. The three low bits of x choose the column and the three low bits of y choose the row, so a fill tiles the same way wherever a rectangle starts. Within each 8-bit row the bit order is reversed: the lowest bit of a row is the rightmost column. Coordinates enter through a valid/ready handshake, one per cycle. The resulting color appears on a registered output one cycle after acceptance.

Top module: `mono_pat_expand`

## Requirements
- R1: While reset is held and in the first cycle after it, out_valid is 0 and in_ready is 1.
- R2: Pattern rows 0 to 3 are read from pat_lo and rows 4 to 7 from pat_hi; a bit in the word not selected never affects the output.
- R3: For pattern row r and column c, the cell is bit 8*(r mod 4) + (7 - c) of the selected word, so row bit 0 is column 7 and row bit 7 is column 0.
- R4: A set cell yields fg_color on out_color and a clear cell yields bg_color.
- R5: The column is dst_x mod 8 and the row is dst_y mod 8; all higher coordinate bits are ignored.
- R6: A coordinate accepted (in_valid and in_ready high at a clock edge) sets out_valid and its color on out_color after that same edge; with out_ready high and no new input, out_valid drops after the next edge.
- R7: While out_valid is 1 and out_ready is 0, in_ready is 0 and out_valid and out_color hold their values.
- R8: Pattern words and colors are sampled when a coordinate is accepted, so a change takes effect for the next coordinate accepted, even one in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_lo | input | 32 | Pattern rows 0 to 3 |
| pat_hi | input | 32 | Pattern rows 4 to 7 |
| fg_color | input | CW | Color for set pattern bits |
| bg_color | input | CW | Color for clear pattern bits |
| in_valid | input | 1 | Coordinate present |
| in_ready | output | 1 | Coordinate can be taken this cycle |
| dst_x | input | XW | Destination x |
| dst_y | input | XW | Destination y |
| out_valid | output | 1 | out_color holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_color | output | CW | Expanded pixel color |

## Verification
The only state is the output register. A wrong bit index or word choice therefore appears on out_color one cycle after the affected coordinate is accepted. It shows as a swapped foreground and background at a specific (x mod 8, y mod 8). Mirrored columns and swapped row halves give errors at fixed cells, so sweeping all 64 cells with asymmetric patterns exposes them at once. A wrong valid or stall flag shows as a lost or duplicated result, or as a color that changes during backpressure, in the cycle right after the stall begins.

// File: rtl/mono_pat_expand.sv
module mono_pat_expand #(
  parameter int CW = 32,
  parameter int XW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   pat_lo,
  input  logic [31:0]   pat_hi,
  input  logic [CW-1:0] fg_color,
  input  logic [CW-1:0] bg_color,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [XW-1:0] dst_x,
  input  logic [XW-1:0] dst_y,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [CW-1:0] out_color
);
  localparam int CELL_BITS = 3;

  logic [CELL_BITS-1:0] col, row;
  logic [31:0]          half;
  logic [4:0]           idx;
  logic                 hit;

  assign col  = dst_x[CELL_BITS-1:0];
  assign row  = dst_y[CELL_BITS-1:0];
  assign half = row[2] ? pat_hi : pat_lo;
  assign idx  = {row[1:0], ~col};
  assign hit  = half[idx];

  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_color <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_color <= hit ? fg_color : bg_color;
    end
  end
endmodule

// File: rtl/mono_pat_expand_chk.sv
module mono_pat_expand_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] fg_color,
  input logic [CW-1:0] bg_color,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [CW-1:0] out_color
);
  assert_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_color)));

  assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_color_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_color == $past(fg_color) || out_color == $past(bg_color)));
endmodule

bind mono_pat_expand mono_pat_expand_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fg_color(fg_color), .bg_color(bg_color),
  .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_color(out_color)
);

// File: tb/mono_pat_expand_bench.sv
module mono_pat_expand_bench;
  localparam int CW = 32;
  localparam int XW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   pat_lo = '0, pat_hi = '0;
  logic [CW-1:0] fg_color = '0, bg_color = '0;
  logic          in_valid = 1'b0, out_ready = 1'b1;
  logic [XW-1:0] dst_x = '0, dst_y = '0;
  logic          in_ready, out_valid;
  logic [CW-1:0] out_color;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mono_pat_expand #(.CW(CW), .XW(XW)) u_mono_pat_expand (
    .clk(clk), .rst_n(rst_n), .pat_lo(pat_lo), .pat_hi(pat_hi),
    .fg_color(fg_color), .bg_color(bg_color), .in_valid(in_valid),
    .in_ready(in_ready), .dst_x(dst_x), .dst_y(dst_y),
    .out_valid(out_valid), .out_ready(out_ready), .out_color(out_color)
  );

  function automatic logic [CW-1:0] model(input logic [31:0] lo, input logic [31:0] hi,
                                          input logic [CW-1:0] fg, input logic [CW-1:0] bg,
                                          input int x, input int y);
    int r = y % 8;
    int c = x % 8;
    logic [31:0] w = (r < 4) ? lo : hi;
    return w[8 * (r % 4) + (7 - c)] ? fg : bg;
  endfunction

  task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input int x, input int y);
    @(negedge clk);
    dst_x = XW'(x); dst_y = XW'(y); in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic send_check(input string req, input int x, input int y);
    logic [CW-1:0] exp = model(pat_lo, pat_hi, fg_color, bg_color, x, y);
    send(x, y);
    check({req, " valid"}, CW'(out_valid), CW'(1));
    check(req, out_color, exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 out_valid in reset", CW'(out_valid), CW'(0));
    check("R1 in_ready in reset", CW'(in_ready), CW'(1));
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 out_valid after reset", CW'(out_valid), CW'(0));
  endtask

  task automatic t_mirror();
    fg_color = 32'hFFFF_0001; bg_color = 32'h0000_BEEF;
    pat_lo = 32'h0000_0001; pat_hi = 32'h0000_0000;
    send_check("R3 bit0 is col7", 7, 0);
    check("R4 set gives fg", out_color, 32'hFFFF_0001);
    send_check("R3 col0 clear", 0, 0);
    check("R4 clear gives bg", out_color, 32'h0000_BEEF);
    pat_lo = 32'h0000_8000;
    send_check("R3 bit15 is row1 col0", 0, 1);
  endtask

  task automatic t_halves();
    fg_color = 32'h1111_1111; bg_color = 32'h2222_2222;
    pat_lo = 32'h0000_0000; pat_hi = 32'h0000_0100;
    send_check("R2 hi word row5 col7", 7, 5);
    check("R2 row5 fg", out_color, 32'h1111_1111);
    send_check("R2 lo word row1 col7 unaffected", 7, 1);
    check("R2 row1 bg", out_color, 32'h2222_2222);
    pat_lo = 32'hFFFF_FFFF; pat_hi = 32'h0000_0000;
    send_check("R2 row4 from hi", 3, 4);
    check("R2 row4 bg", out_color, 32'h2222_2222);
  endtask

  task automatic t_sweep();
    fg_color = 32'hA5A5_0F0F; bg_color = 32'h5A5A_F0F0;
    pat_lo = 32'h8142_2418; pat_hi = 32'h0F1E_3C78;
    for (int y = 0; y < 8; y++)
      for (int x = 0; x < 8; x++)
        send_check("R3 R4 sweep", x, y);
  endtask

  task automatic t_random();
    for (int n = 0; n < 40; n++) begin
      pat_lo = $urandom; pat_hi = $urandom;
      fg_color = $urandom; bg_color = ~fg_color;
      for (int k = 0; k < 8; k++)
        send_check("R2 R3 random", int'($urandom % 4096), int'($urandom % 4096));
    end
  endtask

  task automatic t_wrap();
    fg_color = 32'hCAFE_0000; bg_color = 32'h0000_CAFE;
    pat_lo = 32'h0102_0408; pat_hi = 32'h1020_4080;
    send_check("R5 high x bits ignored", 12'hFF8 + 4, 12'h7F0 + 3);
    send_check("R5 max coords", 4095, 4095);
    send_check("R5 coordinate 8,8 maps to 0,0", 8, 8);
    check("R5 8,8 equals 0,0", out_color, model(pat_lo, pat_hi, fg_color, bg_color, 0, 0));
  endtask

  task automatic t_stream();
    fg_color = 32'h0000_00F0; bg_color = 32'h0000_000F;
    pat_lo = 32'h0000_0080; pat_hi = 32'h0;
    @(negedge clk);
    dst_x = 0; dst_y = 0; in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk); #1;
    check("R6 first result", out_color, 32'h0000_00F0);
    @(negedge clk);
    dst_x = 1; fg_color = 32'h0000_0AAA; bg_color = 32'h0000_0BBB;
    @(posedge clk); #1;
    check("R8 new colors next cycle", out_color, 32'h0000_0BBB);
    check("R6 back to back valid", CW'(out_valid), CW'(1));
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
    check("R6 drains", CW'(out_valid), CW'(0));
  endtask

  task automatic t_stall();
    fg_color = 32'h0000_1234; bg_color = 32'h0000_5678;
    pat_lo = 32'h0000_0080; pat_hi = 32'h0;
    @(negedge clk);
    dst_x = 0; dst_y = 0; in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk); #1;
    check("R6 accepted into empty", out_color, 32'h0000_1234);
    @(negedge clk);
    dst_x = 1;
    check("R7 in_ready low while stalled", CW'(in_ready), CW'(0));
    @(posedge clk); #1;
    check("R7 color held", out_color, 32'h0000_1234);
    check("R7 valid held", CW'(out_valid), CW'(1));
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk); #1;
    check("R7 release takes next", out_color, 32'h0000_5678);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    t_reset();
    t_mirror();
    t_halves();
    t_sweep();
    t_wrap();
    t_stream();
    t_stall();
    t_random();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule